// File: doc/BRIEF.md
# General-Purpose I/O Port with Read-Modify-Write Bit Operations

This block is an 8-bit general-purpose I/O port. Each pin has a direction bit and an output data latch. An output pin drives its latch bit, and its output enable is taken from the direction bit. The external pin levels pass through a synchronizer before anything reads them. A read of the data address gives the synchronized pin level for input bits and the latch value for output bits.

A bit-operation unit can set or clear one bit of the data latch. It does this in three steps: it reads the whole port as a read of the data address would see it, it changes the one addressed bit, and it writes the full byte back into the latch. Because of this, the latch bits of input-configured pins pick up the sampled pin levels and lose their earlier contents. Software that later turns those pins into outputs sees the new values. A direct bus write to the data address loads the whole latch as written, with no such side effect.

Top module: `gpio_rmw_port`

## Requirements
- R1: After reset, the direction register and the data latch are 0. So pin_oe = 0x00, pin_out = 0x00, op_busy = 0 and op_done = 0, and a read of address 1 returns 0x00.
- R2: Address 1 holds the direction register, where bit value 1 means output. pin_oe equals the direction register bit for bit, and pin_out always carries the full data latch.
- R3: A read of address 0 returns, for each bit, the synchronized pin level when the direction bit is 0 and the latch bit when the direction bit is 1. bus_rdata is combinational on bus_addr.
- R4: A pin_in change reaches the read path after exactly two rising clock edges (two-flop synchronizer).
- R5: A bus write to address 0 (bus_we = 1) loads all 8 latch bits as written, whatever the direction settings.
- R6: A set operation (op_set = 1) forces bit op_bit to 1 in the port read value and writes that whole byte into the latch. For example, with direction 0x3F, pins 7 and 6 at low and high, and latch 0x80, the port reads 0x40 and setting bit 0 leaves the latch at 0x41.
- R7: A clear operation (op_set = 0) uses the same sequence but forces bit op_bit to 0.
- R8: After a bit operation, the latch bits of input-configured pins hold the pin levels sampled during the read step.
- R9: op_req is accepted on a rising edge while idle. op_busy is then high for exactly three cycles. The latch holds the new byte in the cycle after op_busy falls, and op_done is high for that single cycle.
- R10: An op_req seen while op_busy is high is ignored. It neither starts a second operation nor changes the result.
- R11: When a bit operation commits on the same edge as a bus write to address 0, the bit-operation result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register address: 0 data, 1 direction |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | WIDTH | Register write data |
| bus_rdata | output | WIDTH | Register read data (combinational) |
| op_req | input | 1 | Bit-operation request |
| op_bit | input | IDX_W | Index of the bit to change |
| op_set | input | 1 | 1 sets the bit, 0 clears it |
| op_busy | output | 1 | Bit operation in progress |
| op_done | output | 1 | One-cycle pulse when the result is in the latch |
| pin_in | input | WIDTH | External pin levels |
| pin_out | output | WIDTH | Pin drive values (data latch) |
| pin_oe | output | WIDTH | Pin output enables (direction) |

## Verification
Bit operations are tried on several patterns:
- An all-output port, where only the target bit should change.
- The mixed 0x3F-direction case, where the two input pins disagree with their stale latch bits. This separates a read of the latch from a read of the port.
- A half-input port with a clear operation, which shows whether input latch bits are rewritten from the pins or left alone.

Mixed direction and pin patterns on direct reads check that the read mux selects per bit. Requests made during a running operation, and a bus write on the commit edge, check that the unit ignores the request and that the commit wins.

// File: rtl/gpio_rmw_pkg.sv
`timescale 1ns/1ps
package gpio_rmw_pkg;

   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_READ   = 2'd1,
      OP_MODIFY = 2'd2,
      OP_WRITE  = 2'd3
   } op_state_e;

   localparam int unsigned REG_DATA = 0;
   localparam int unsigned REG_DIR  = 1;

endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   generate
      if (STAGES > 4) begin : g_bad_stages
         $error("gpio_pin_sync: STAGES must be 0..4");
      end

      if (STAGES == 0) begin : g_bypass
         assign sync_out = async_in;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
            end else begin
               stage_q[0] <= async_in;
               for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
            end
         end

         assign sync_out = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
   import gpio_rmw_pkg::*;
#(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [WIDTH-1:0]  bus_wdata,
   input  logic              commit,
   input  logic [WIDTH-1:0]  commit_val,
   input  logic [WIDTH-1:0]  pin_sync,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  latch_q,
   output logic [WIDTH-1:0]  port_view,
   output logic [WIDTH-1:0]  bus_rdata
);

   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(REG_DATA);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(REG_DIR);

   logic wr_data, wr_dir;

   assign wr_data = bus_we && (bus_addr == A_DATA);
   assign wr_dir  = bus_we && (bus_addr == A_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (wr_dir) begin
         dir_q <= bus_wdata;
      end
   end

   // the bit-operation commit has priority over a bus data write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (commit) begin
         latch_q <= commit_val;
      end else if (wr_data) begin
         latch_q <= bus_wdata;
      end
   end

   // per-bit view: latch for outputs, synchronized pin for inputs
   always_comb begin
      for (int b = 0; b < int'(WIDTH); b++) begin
         port_view[b] = dir_q[b] ? latch_q[b] : pin_sync[b];
      end
   end

   always_comb begin
      if (bus_addr == A_DATA)      bus_rdata = port_view;
      else if (bus_addr == A_DIR)  bus_rdata = dir_q;
      else                         bus_rdata = '0;
   end

   // R11
   commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (latch_q == $past(commit_val)));

   // R2
   dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> (dir_q == $past(bus_wdata)));

endmodule

// File: rtl/gpio_bitop_seq.sv
`timescale 1ns/1ps
module gpio_bitop_seq
   import gpio_rmw_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_req,
   input  logic [IDX_W-1:0] op_bit,
   input  logic             op_set,
   input  logic [WIDTH-1:0] port_view,
   output logic             busy,
   output logic             done,
   output logic             commit,
   output logic [WIDTH-1:0] commit_val,
   output logic [IDX_W-1:0] tgt_bit,
   output logic             tgt_val
);

   op_state_e        state_q;
   logic [WIDTH-1:0] snap_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= OP_IDLE;
         snap_q  <= '0;
         tgt_bit <= '0;
         tgt_val <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= (state_q == OP_WRITE);
         unique case (state_q)
            OP_IDLE: begin
               if (op_req) begin
                  tgt_bit <= op_bit;
                  tgt_val <= op_set;
                  state_q <= OP_READ;
               end
            end
            OP_READ: begin
               snap_q  <= port_view;
               state_q <= OP_MODIFY;
            end
            OP_MODIFY: begin
               for (int b = 0; b < int'(WIDTH); b++) begin
                  if (tgt_bit == IDX_W'(b)) snap_q[b] <= tgt_val;
               end
               state_q <= OP_WRITE;
            end
            OP_WRITE: begin
               state_q <= OP_IDLE;
            end
            default: state_q <= OP_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != OP_IDLE);
   assign commit     = (state_q == OP_WRITE);
   assign commit_val = snap_q;
   assign done       = done_q;

   // R9
   write_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == OP_WRITE) |=> (done && !busy));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_req && state_q != OP_WRITE) |=> (state_q != OP_READ));

endmodule

// File: rtl/gpio_rmw_port.sv
`timescale 1ns/1ps
module gpio_rmw_port #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned IDX_W      = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic              op_req,
   input  logic [IDX_W-1:0]  op_bit,
   input  logic              op_set,
   output logic              op_busy,
   output logic              op_done,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe
);

   generate
      if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
         $error("gpio_rmw_port: WIDTH must be 2..64");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("gpio_rmw_port: ADDR_W must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] pin_sync;
   logic [WIDTH-1:0] dir_q, latch_q, port_view;
   logic             commit;
   logic [WIDTH-1:0] commit_val;
   logic [IDX_W-1:0] tgt_bit;
   logic             tgt_val;

   gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   gpio_port_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_we     (bus_we),
      .bus_wdata  (bus_wdata),
      .commit     (commit),
      .commit_val (commit_val),
      .pin_sync   (pin_sync),
      .dir_q      (dir_q),
      .latch_q    (latch_q),
      .port_view  (port_view),
      .bus_rdata  (bus_rdata)
   );

   gpio_bitop_seq #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_req     (op_req),
      .op_bit     (op_bit),
      .op_set     (op_set),
      .port_view  (port_view),
      .busy       (op_busy),
      .done       (op_done),
      .commit     (commit),
      .commit_val (commit_val),
      .tgt_bit    (tgt_bit),
      .tgt_val    (tgt_val)
   );

   assign pin_out = latch_q;
   assign pin_oe  = dir_q;

   // R6 R7
   done_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_done |-> (latch_q[tgt_bit] == tgt_val));

endmodule

// File: tb/tb_gpio_rmw_port.sv
`timescale 1ns/1ps
module tb_gpio_rmw_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       op_req = 1'b0;
   logic [2:0] op_bit = '0;
   logic       op_set = 1'b0;
   logic       op_busy, op_done;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_out, pin_oe;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #5 clk = ~clk;

   gpio_rmw_port dut (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .op_req(op_req), .op_bit(op_bit), .op_set(op_set),
      .op_busy(op_busy), .op_done(op_done),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      tick();
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic set_pins(input logic [7:0] p);
      pin_in = p;
      tick(); tick();
   endtask

   // full bit operation with timing checks; at a negedge on entry and exit
   task automatic bit_op(input logic [2:0] idx, input logic s, input logic [7:0] exp_latch);
      op_bit = idx; op_set = s; op_req = 1'b1;
      tick();
      op_req = 1'b0;
      for (int c = 0; c < 3; c++) begin
         chk("R9", "busy during op", {7'd0, op_busy}, 8'h01);
         chk("R9", "done low during op", {7'd0, op_done}, 8'h00);
         tick();
      end
      chk("R9", "busy low after op", {7'd0, op_busy}, 8'h00);
      chk("R9", "done pulse", {7'd0, op_done}, 8'h01);
      chk(s ? "R6" : "R7", "latch after op", pin_out, exp_latch);
      tick();
      chk("R9", "done one cycle", {7'd0, op_done}, 8'h00);
   endtask

   task automatic t_reset();
      logic [7:0] r;
      chk("R1", "pin_oe", pin_oe, 8'h00);
      chk("R1", "pin_out", pin_out, 8'h00);
      chk("R1", "busy", {7'd0, op_busy}, 8'h00);
      chk("R1", "done", {7'd0, op_done}, 8'h00);
      bus_rd(2'd1, r);
      chk("R1", "dir read", r, 8'h00);
   endtask

   task automatic t_dir_and_read();
      logic [7:0] r;
      bus_wr(2'd1, 8'h0F);
      bus_wr(2'd0, 8'hA5);
      chk("R2", "pin_oe follows dir", pin_oe, 8'h0F);
      chk("R5", "latch takes all bits", pin_out, 8'hA5);
      bus_rd(2'd1, r);
      chk("R2", "dir readback", r, 8'h0F);
      set_pins(8'h3C);
      bus_rd(2'd0, r);
      chk("R3", "mixed port read", r, 8'h35);
      bus_wr(2'd1, 8'hFF);
      bus_rd(2'd0, r);
      chk("R5", "input latch bits kept from bus write", r, 8'hA5);
   endtask

   task automatic t_sync();
      logic [7:0] r;
      bus_wr(2'd1, 8'h00);
      set_pins(8'h00);
      pin_in = 8'h99;
      tick();
      bus_rd(2'd0, r);
      chk("R4", "one edge: old level", r, 8'h00);
      tick();
      bus_rd(2'd0, r);
      chk("R4", "two edges: new level", r, 8'h99);
   endtask

   task automatic t_example();
      logic [7:0] r;
      bus_wr(2'd1, 8'h3F);
      bus_wr(2'd0, 8'h80);
      set_pins(8'h40);
      bus_rd(2'd0, r);
      chk("R3", "example port read", r, 8'h40);
      bit_op(3'd0, 1'b1, 8'h41);
      chk("R6", "pin 0 enabled", pin_oe, 8'h3F);
      bus_rd(2'd0, r);
      chk("R6", "port read after set", r, 8'h41);
      bus_wr(2'd1, 8'hFF);
      bus_rd(2'd0, r);
      chk("R8", "input latch bits from pins", r, 8'h41);
   endtask

   task automatic t_clear();
      bus_wr(2'd1, 8'hF0);
      bus_wr(2'd0, 8'hFF);
      set_pins(8'h0A);
      bit_op(3'd7, 1'b0, 8'h7A);
      chk("R8", "low nibble from pins", pin_out & 8'h0F, 8'h0A);
      chk("R7", "oe unchanged", pin_oe, 8'hF0);
   endtask

   task automatic t_busy_ignore();
      bus_wr(2'd1, 8'hFF);
      bus_wr(2'd0, 8'h00);
      op_bit = 3'd2; op_set = 1'b1; op_req = 1'b1;
      tick();
      op_bit = 3'd5;
      tick();
      tick();
      op_req = 1'b0;
      chk("R10", "still busy", {7'd0, op_busy}, 8'h01);
      tick();
      chk("R10", "first op done", {7'd0, op_done}, 8'h01);
      chk("R10", "only first bit set", pin_out, 8'h04);
      tick(); tick(); tick(); tick();
      chk("R10", "no second op", pin_out, 8'h04);
      chk("R10", "idle after", {7'd0, op_busy}, 8'h00);
   endtask

   task automatic t_collide();
      bus_wr(2'd0, 8'h00);
      op_bit = 3'd1; op_set = 1'b1; op_req = 1'b1;
      tick();
      op_req = 1'b0;
      tick(); tick();
      bus_addr = 2'd0; bus_wdata = 8'hAA; bus_we = 1'b1;
      tick();
      bus_we = 1'b0;
      chk("R11", "commit wins", pin_out, 8'h02);
      bus_wr(2'd0, 8'h55);
      chk("R5", "bus write after op", pin_out, 8'h55);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!ended) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_dir_and_read();
      t_sync();
      t_example();
      t_clear();
      t_busy_ignore();
      t_collide();
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule